// File: doc/BRIEF.md
# Scale-Factor Replicating Stager

This block moves 8-bit block-scale factors from a staging buffer into a tensor-memory array. The array is addressed by a lane (0..127) and a column, and each cell is 32 bits wide. The scale factors for a 128-row operand are kept as one compact group of 32 rows. Every packed cell of that group is written four times, once into each 32-lane window of the array, so all 128 lanes can read it.

A job starts with a pulse on `start_i`, which also selects the packing mode. The block then reads scale bytes over a valid/ready stream, one byte per accepted beat. Each 32-bit cell is built from one, two or four bytes, depending on the mode. For each cell the block issues four write commands over a valid/ready port, giving the lane, the column and the packed word. After the last write, `done_o` goes high and stays high until the next job starts. The bulk copy that fills the staging buffer and the multiply that reads the scales are separate blocks.

The stream carries the bytes cell by cell. The column changes slowest, then the row, then the byte within the cell. The first byte of a cell belongs to the lowest scale block of that cell.

Top module: `sf_replicate_stager`

## Requirements
- R1: While reset is asserted and after it is released, `wr_valid_o`, `sf_ready_o` and `done_o` are all 0.
- R2: `start_i` is acted on only while idle or done. In either state it latches `mode_i`, clears `done_o` and starts accepting bytes on the next cycle. A `start_i` pulse during a job changes neither the job's mode nor its write sequence.
- R3: Writes are issued with the window index q changing fastest, then the row r (0..31), then the column c (0..NUM_COLS-1). The lane is r + 32*q, which places q in lane bits [6:5] and r in lane bits [4:0]. The column equals c.
- R4: Mode code 0 (1X) uses one byte b0 per cell and writes the word {b0,b0,b0,b0}.
- R5: Mode code 1 (2X) uses two bytes per cell, with b0 accepted first. It writes {b1,b1,b0,b0}, where the least significant byte is bits [7:0].
- R6: Mode code 2 (4X) uses four bytes per cell, accepted in the order b0, b1, b2, b3. It writes {b3,b2,b1,b0}.
- R7: Mode code 3 is treated exactly like 1X.
- R8: All four window copies of a cell carry the same column and the same data word.
- R9: While `wr_valid_o` is high and `wr_ready_i` is low, the write lane, column and data stay unchanged on the next cycle, and `wr_valid_o` stays high.
- R10: `sf_ready_o` and `wr_valid_o` are never high in the same cycle. Bytes are accepted only on cycles where both `sf_valid_i` and `sf_ready_o` are high.
- R11: A job issues exactly 4*32*NUM_COLS writes. `done_o` rises in the cycle after the final write handshake and stays high, with no write and no byte request, until the next start.
- R12: Gaps in `sf_valid_i` and stalls on `wr_ready_i` change only the timing of the writes, never their addresses, data or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a job |
| mode_i | input | 2 | Packing mode: 0=1X, 1=2X, 2=4X, 3=treated as 1X |
| sf_valid_i | input | 1 | Scale byte valid |
| sf_ready_o | output | 1 | Stager accepts a scale byte |
| sf_byte_i | input | 8 | Scale byte |
| wr_valid_o | output | 1 | Write command valid |
| wr_ready_i | input | 1 | Memory accepts the write |
| wr_lane_o | output | 7 | Target lane, r + 32*q |
| wr_col_o | output | 2 | Target column (log2 of NUM_COLS) |
| wr_data_o | output | 32 | Packed cell word |
| done_o | output | 1 | Job complete, held until the next start |

## Verification
The bench checks the byte placement of each mode against its own packing model.
- If the first byte were put in the high lane, 2X and 4X data would come out mirrored.
- If mode code 3 were decoded as 4X, the block would request too many bytes and the data would shift.

The bench also checks the window stride and the write ordering, with input gaps and output backpressure mixed in.
- If the window stride were wrong, copies would land on lanes r + q instead of r + 32*q.
- If data changed during a stall, the held write would be corrupted.
- If a counter wrapped at the wrong point, the job would end early, or `done_o` would be off by a cycle.

Finally, the bench pulses start in the middle of a 4X job with a different mode. A design that re-latched the mode at that point would change the packing partway through the job.

// File: rtl/sf_stage_pkg.sv
package sf_stage_pkg;

  typedef enum logic [1:0] {
    SCALE_1X  = 2'd0,
    SCALE_2X  = 2'd1,
    SCALE_4X  = 2'd2,
    SCALE_RSV = 2'd3
  } scale_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_EMIT = 2'd2,
    ST_DONE = 2'd3
  } stage_state_e;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CELL_BYTES = 4;
  localparam int unsigned CELL_W     = BYTE_W * CELL_BYTES;

  // bytes consumed per cell; reserved code behaves as 1X
  function automatic logic [2:0] bytes_per_cell(scale_mode_e mode);
    case (mode)
      SCALE_2X: return 3'd2;
      SCALE_4X: return 3'd4;
      default:  return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/sf_byte_gather.sv
module sf_byte_gather
  import sf_stage_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clear_i,
  input  logic                             take_i,
  input  logic [BYTE_W-1:0]                byte_i,
  input  logic [2:0]                       need_i,
  output logic [CELL_BYTES-1:0][BYTE_W-1:0] bytes_o,
  output logic                             last_o
);

  localparam int unsigned CNT_W = $clog2(CELL_BYTES);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = (3'({1'b0, cnt_q}) + 3'd1) == need_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (take_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < CELL_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bytes_o[g] <= '0;
      end else if (take_i && (cnt_q == CNT_W'(g))) begin
        bytes_o[g] <= byte_i;
      end
    end
  end

  AST_SLOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (3'({1'b0, cnt_q}) < need_i)); // R6

endmodule

// File: rtl/sf_cell_pack.sv
module sf_cell_pack
  import sf_stage_pkg::*;
(
  input  scale_mode_e                      mode_i,
  input  logic [CELL_BYTES-1:0][BYTE_W-1:0] bytes_i,
  output logic [CELL_W-1:0]                word_o
);

  always_comb begin
    case (mode_i)
      SCALE_2X: word_o = {bytes_i[1], bytes_i[1], bytes_i[0], bytes_i[0]};
      SCALE_4X: word_o = {bytes_i[3], bytes_i[2], bytes_i[1], bytes_i[0]};
      default:  word_o = {CELL_BYTES{bytes_i[0]}};
    endcase
  end

endmodule

// File: rtl/sf_lane_walker.sv
module sf_lane_walker #(
  parameter int unsigned GROUP_ROWS = 32,
  parameter int unsigned WINDOWS    = 4,
  parameter int unsigned NUM_COLS   = 4,
  localparam int unsigned LANES     = GROUP_ROWS * WINDOWS,
  localparam int unsigned LANE_W    = $clog2(LANES),
  localparam int unsigned COL_W     = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [LANE_W-1:0] lane_o,
  output logic [COL_W-1:0]  col_o,
  output logic              cell_done_o,
  output logic              last_o
);

  localparam int unsigned QW = (WINDOWS > 1) ? $clog2(WINDOWS) : 1;
  localparam int unsigned RW = (GROUP_ROWS > 1) ? $clog2(GROUP_ROWS) : 1;

  logic [QW-1:0]    q_q;
  logic [RW-1:0]    r_q;
  logic [COL_W-1:0] c_q;
  logic q_last, r_last, c_last;

  assign q_last = q_q == QW'(WINDOWS - 1);
  assign r_last = r_q == RW'(GROUP_ROWS - 1);
  assign c_last = c_q == COL_W'(NUM_COLS - 1);

  assign lane_o      = LANE_W'(q_q) * LANE_W'(GROUP_ROWS) + LANE_W'(r_q);
  assign col_o       = c_q;
  assign cell_done_o = q_last;
  assign last_o      = q_last && r_last && c_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
      r_q <= '0;
      c_q <= '0;
    end else if (clear_i) begin
      q_q <= '0;
      r_q <= '0;
      c_q <= '0;
    end else if (step_i) begin
      q_q <= q_last ? '0 : q_q + 1'b1;
      if (q_last) begin
        r_q <= r_last ? '0 : r_q + 1'b1;
        if (r_last) c_q <= c_last ? '0 : c_q + 1'b1;
      end
    end
  end

  AST_WINDOW_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clear_i && !q_last |=> lane_o == $past(lane_o) + LANE_W'(GROUP_ROWS)); // R3

  AST_COL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clear_i && !(q_last && r_last) |=> col_o == $past(col_o)); // R8

endmodule

// File: rtl/sf_replicate_stager.sv
module sf_replicate_stager
  import sf_stage_pkg::*;
#(
  parameter int unsigned NUM_COLS   = 4,
  parameter int unsigned GROUP_ROWS = 32,
  parameter int unsigned WINDOWS    = 4,
  localparam int unsigned LANES     = GROUP_ROWS * WINDOWS,
  localparam int unsigned LANE_W    = $clog2(LANES),
  localparam int unsigned COL_W     = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              sf_valid_i,
  output logic              sf_ready_o,
  input  logic [7:0]        sf_byte_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [LANE_W-1:0] wr_lane_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic [31:0]       wr_data_o,
  output logic              done_o
);

  stage_state_e state_q;
  scale_mode_e  mode_q;
  logic launch, take, step, gather_last, cell_done, walk_last;
  logic [CELL_BYTES-1:0][BYTE_W-1:0] cell_bytes;

  assign launch     = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign sf_ready_o = state_q == ST_FILL;
  assign wr_valid_o = state_q == ST_EMIT;
  assign done_o     = state_q == ST_DONE;
  assign take       = sf_ready_o && sf_valid_i;
  assign step       = wr_valid_o && wr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= SCALE_1X;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (launch) begin
          state_q <= ST_FILL;
          mode_q  <= scale_mode_e'(mode_i);
        end
        ST_FILL: if (take && gather_last) state_q <= ST_EMIT;
        ST_EMIT: if (step && cell_done)   state_q <= walk_last ? ST_DONE : ST_FILL;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sf_byte_gather i_gather (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (launch),
    .take_i  (take),
    .byte_i  (sf_byte_i),
    .need_i  (bytes_per_cell(mode_q)),
    .bytes_o (cell_bytes),
    .last_o  (gather_last)
  );

  sf_cell_pack i_pack (
    .mode_i  (mode_q),
    .bytes_i (cell_bytes),
    .word_o  (wr_data_o)
  );

  sf_lane_walker #(
    .GROUP_ROWS (GROUP_ROWS),
    .WINDOWS    (WINDOWS),
    .NUM_COLS   (NUM_COLS)
  ) i_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (launch),
    .step_i      (step),
    .lane_o      (wr_lane_o),
    .col_o       (wr_col_o),
    .cell_done_o (cell_done),
    .last_o      (walk_last)
  );

  AST_HOLD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_lane_o) && $stable(wr_col_o)
                                  && $stable(wr_data_o)); // R9

  AST_IO_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_o && sf_ready_o)); // R10

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_valid_o && !sf_ready_o); // R11

  AST_DONE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(wr_valid_o && wr_ready_i)); // R11

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL || state_q == ST_EMIT) |=> $stable(mode_q)); // R2

  AST_PAIR_DUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && mode_q == SCALE_2X |-> wr_data_o[15:8] == wr_data_o[7:0]
                                         && wr_data_o[31:24] == wr_data_o[23:16]); // R5

  AST_REPLICA_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && !cell_done |=> wr_valid_o && wr_data_o == $past(wr_data_o)); // R8

endmodule

// File: tb/test_sf_replicate_stager.sv
module test_sf_replicate_stager;

  localparam int NUM_COLS = 4;
  localparam int ROWS     = 32;
  localparam int WIN      = 4;
  localparam int TOTAL_WR = WIN * ROWS * NUM_COLS;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       sf_valid_i = 1'b0;
  logic       sf_ready_o;
  logic [7:0] sf_byte_i = 8'd0;
  logic       wr_valid_o;
  logic       wr_ready_i = 1'b0;
  logic [6:0] wr_lane_o;
  logic [1:0] wr_col_o;
  logic [31:0] wr_data_o;
  logic       done_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  sf_replicate_stager #(.NUM_COLS(NUM_COLS)) i_sf_replicate_stager (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .sf_valid_i (sf_valid_i),
    .sf_ready_o (sf_ready_o),
    .sf_byte_i  (sf_byte_i),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_lane_o  (wr_lane_o),
    .wr_col_o   (wr_col_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gen_byte(int c, int r, int j, int seed);
    return 8'((c * 61 + r * 7 + j * 113 + seed) & 255);
  endfunction

  function automatic int bytes_for(logic [1:0] m);
    if (m == 2'd1) return 2;
    if (m == 2'd2) return 4;
    return 1;
  endfunction

  function automatic logic [31:0] exp_word(logic [1:0] m, int c, int r, int seed);
    logic [7:0] b0, b1, b2, b3;
    b0 = gen_byte(c, r, 0, seed);
    b1 = gen_byte(c, r, 1, seed);
    b2 = gen_byte(c, r, 2, seed);
    b3 = gen_byte(c, r, 3, seed);
    if (m == 2'd1) return {b1, b1, b0, b0};
    if (m == 2'd2) return {b3, b2, b1, b0};
    return {b0, b0, b0, b0};
  endfunction

  task automatic test_reset();
    #1;
    check(!wr_valid_o && !sf_ready_o && !done_o, "R1", "outputs in reset",
          {29'd0, wr_valid_o, sf_ready_o, done_o}, 32'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(!wr_valid_o && !sf_ready_o && !done_o, "R1", "outputs after reset",
          {29'd0, wr_valid_o, sf_ready_o, done_o}, 32'd0);
  endtask

  // one job; in_gap/out_bp of 0 means no stalls
  task automatic run_job(input logic [1:0] mode, input int seed, input int in_gap,
                         input int out_bp, input bit mid_start, input string dreq);
    int k, total_bytes, src_m, n, last_fire, done_cyc;
    bit held, excl_bad, dup_bad;
    logic [6:0] h_lane;
    logic [1:0] h_col;
    logic [31:0] h_data, prev_data;
    k = bytes_for(mode);
    total_bytes = k * ROWS * NUM_COLS;
    src_m = 0; n = 0; last_fire = -10; done_cyc = -1;
    held = 0; excl_bad = 0; dup_bad = 0; prev_data = '0;
    @(negedge clk);
    start_i = 1'b1;
    mode_i  = mode;
    @(negedge clk);
    start_i = 1'b0;
    mode_i  = ~mode;
    check(!done_o && sf_ready_o, "R2", "start accepted",
          {30'd0, done_o, sf_ready_o}, 32'd1);
    for (int cyc = 0; cyc < 20000; cyc++) begin
      if (done_o) begin
        done_cyc = cyc;
        break;
      end
      start_i = mid_start && (cyc == 150);
      mode_i  = (cyc == 150) ? 2'd0 : ~mode;
      if (wr_valid_o && sf_ready_o) excl_bad = 1;
      // source
      sf_valid_i = (src_m < total_bytes) && ((in_gap == 0) || (cyc % in_gap != 0));
      if (src_m < total_bytes)
        sf_byte_i = gen_byte(src_m / (k * ROWS), (src_m / k) % ROWS, src_m % k, seed);
      if (sf_valid_i && sf_ready_o) src_m++;
      // sink
      if (held) begin
        check(wr_valid_o && wr_lane_o == h_lane && wr_col_o == h_col && wr_data_o == h_data,
              "R9", "stalled write held", wr_data_o, h_data);
      end
      wr_ready_i = (out_bp == 0) || (cyc % out_bp != 0);
      if (wr_valid_o && wr_ready_i) begin
        int q, r, c;
        q = n % WIN;
        r = (n / WIN) % ROWS;
        c = n / (WIN * ROWS);
        check(wr_lane_o == 7'(r + 32 * q) && wr_col_o == 2'(c), "R3", "lane/col order",
              {23'd0, wr_col_o, wr_lane_o}, {23'd0, 2'(c), 7'(r + 32 * q)});
        check(wr_data_o == exp_word(mode, c, r, seed), dreq, "packed word",
              wr_data_o, exp_word(mode, c, r, seed));
        if (q != 0 && wr_data_o != prev_data) dup_bad = 1;
        prev_data = wr_data_o;
        n++;
        last_fire = cyc;
      end
      held = wr_valid_o && !wr_ready_i;
      h_lane = wr_lane_o;
      h_col  = wr_col_o;
      h_data = wr_data_o;
      @(negedge clk);
    end
    sf_valid_i = 1'b0;
    wr_ready_i = 1'b0;
    start_i    = 1'b0;
    check(!excl_bad, "R10", "byte request and write never together", 32'(excl_bad), 32'd0);
    check(!dup_bad, "R8", "window copies identical", 32'(dup_bad), 32'd0);
    check(n == TOTAL_WR, "R11", "write count", n, TOTAL_WR);
    check(src_m == total_bytes, "R12", "bytes consumed", src_m, total_bytes);
    check(done_cyc == last_fire + 1, "R11", "done timing", done_cyc, last_fire + 1);
  endtask

  task automatic test_1x_plain();
    run_job(2'd0, 5, 0, 0, 1'b0, "R4");
  endtask

  task automatic test_2x_input_gaps();
    run_job(2'd1, 19, 3, 0, 1'b0, "R5");
  endtask

  task automatic test_4x_backpressure_midstart();
    run_job(2'd2, 77, 0, 3, 1'b1, "R6");
  endtask

  task automatic test_reserved_mode();
    run_job(2'd3, 42, 2, 2, 1'b0, "R7");
  endtask

  task automatic test_done_hold();
    bit bad;
    bad = 0;
    sf_valid_i = 1'b1;
    wr_ready_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!done_o || wr_valid_o || sf_ready_o) bad = 1;
    end
    sf_valid_i = 1'b0;
    wr_ready_i = 1'b0;
    check(!bad, "R11", "done held, quiet", {29'd0, done_o, wr_valid_o, sf_ready_o}, 32'd4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    test_reset();
    test_1x_plain();
    test_done_hold();
    test_2x_input_gaps();
    test_4x_backpressure_midstart();
    test_reserved_mode();
    test_done_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule